// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a stereo PCM stream carried on three wires (a bit clock, a left/right word clock and a serial data line) and turns it into parallel 24-bit left and right samples. All three wires are oversampled by the system clock. Each wire passes through a two-flop synchronizer, and the data line is sampled on each detected rising edge of the bit clock. Samples are two's complement and arrive MSB first.

One shift engine handles every framing. A 3-bit format code, held in a small register, selects I2S, left-justified, or right-justified at 24, 20, 18 or 16 bits. Right-justified words are sign-extended to 24 bits. When the right-channel word of a pair is complete, the left and right samples appear together on the outputs with a one-cycle valid strobe. The outputs then hold until the next pair.

Top module: `aud_rx_top`

## Requirements
- R1: The data line is sampled once per rising edge of the synchronized bit clock. Words are assembled MSB first.
- R2: After reset, both sample outputs are zero, the valid strobe is low and the format register holds 000.
- R3: Format code 000 selects I2S. A low word clock marks the left channel. The MSB is sampled on the second bit-clock rising edge after a word-clock transition, followed by the next 23 bits.
- R4: Format code 001 selects left-justified. A high word clock marks the left channel. The MSB is sampled on the first rising edge after a word-clock transition, followed by the next 23 bits.
- R5: Format codes 010, 011, 100 and 101 select right-justified with word lengths 24, 20, 18 and 16. A high word clock marks the left channel. The LSB is the bit sampled on the last rising edge before the next word-clock transition. Shorter words are sign-extended to 24 bits.
- R6: Format codes 110 and 111 behave exactly like code 000.
- R7: The format register loads fmt_i only in a cycle where fmt_wr_i is high. Otherwise fmt_i has no effect.
- R8: Channel slots that are unequal in length (30 and 34 bit clocks, i.e. a 50% word-clock duty off by 2 bit clocks) are received correctly in every framing.
- R9: valid_o is high for exactly one cycle per completed left-then-right pair. left_o and right_o change only in that cycle and otherwise hold their values.
- R10: A right-channel word that is not preceded by a left-channel word since the last pair produces no valid strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_wr_i | input | 1 | Load strobe for the format register |
| fmt_i | input | 3 | Format code to load |
| bck_i | input | 1 | Serial bit clock (asynchronous) |
| lrck_i | input | 1 | Left/right word clock (asynchronous) |
| sdata_i | input | 1 | Serial data line (asynchronous) |
| left_o | output | 24 | Left sample of the last completed pair |
| right_o | output | 24 | Right sample of the last completed pair |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
Each format code is driven with full frames whose sample values differ between channels and whose MSB and LSB are distinct. A one-bit slip in alignment, a swapped channel polarity or a missing sign extension therefore changes the captured value. Right-justified cases use values whose sign bit sits exactly at the selected word length: negative left words check that sign extension happens, and positive right words check that the upper bits clear. Unequal slot lengths separate the three alignment rules. Left-justified capture depends only on the leading edge, right-justified capture only on the trailing edge, and I2S is offset by one bit. A stream that starts with a right word, a reset after a format write, and the two undefined codes cover the pairing rule, the reset default and the fallback.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int FMT_W    = 3;
    localparam int LEN_W    = 5;

    localparam logic [FMT_W-1:0] FMT_I2S24 = 3'b000;
    localparam logic [FMT_W-1:0] FMT_LJ24  = 3'b001;
    localparam logic [FMT_W-1:0] FMT_RJ24  = 3'b010;
    localparam logic [FMT_W-1:0] FMT_RJ20  = 3'b011;
    localparam logic [FMT_W-1:0] FMT_RJ18  = 3'b100;
    localparam logic [FMT_W-1:0] FMT_RJ16  = 3'b101;

    typedef enum logic [1:0] {
        FR_I2S = 2'd0,
        FR_LJ  = 2'd1,
        FR_RJ  = 2'd2
    } frame_e;

    typedef struct packed {
        frame_e           frame;
        logic [LEN_W-1:0] len;
    } fmt_cfg_t;

    typedef struct packed {
        logic                valid;
        logic                is_left;
        logic [SAMPLE_W-1:0] data;
    } word_t;

    function automatic fmt_cfg_t decode_fmt(input logic [FMT_W-1:0] code);
        fmt_cfg_t c;
        c.len = LEN_W'(SAMPLE_W);
        case (code)
            FMT_LJ24: c.frame = FR_LJ;
            FMT_RJ24: c.frame = FR_RJ;
            FMT_RJ20: begin c.frame = FR_RJ; c.len = LEN_W'(20); end
            FMT_RJ18: begin c.frame = FR_RJ; c.len = LEN_W'(18); end
            FMT_RJ16: begin c.frame = FR_RJ; c.len = LEN_W'(16); end
            default:  c.frame = FR_I2S;
        endcase
        return c;
    endfunction

    function automatic logic [SAMPLE_W-1:0] sign_extend(input logic [SAMPLE_W-1:0] raw,
                                                        input logic [LEN_W-1:0]    len);
        logic [SAMPLE_W-1:0] out;
        logic [LEN_W-1:0]    top;
        top = len - LEN_W'(1);
        for (int i = 0; i < SAMPLE_W; i++) begin
            out[i] = (LEN_W'(i) <= top) ? raw[i] : raw[top];
        end
        return out;
    endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/aud_rx_shift.sv
module aud_rx_shift
    import aud_rx_pkg::*;
#(
    parameter int MAX_SLOT = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rise,
    input  logic     lr,
    input  logic     din,
    input  fmt_cfg_t cfg,
    output word_t    word_o
);
    localparam int CNT_W = $clog2(MAX_SLOT);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(SAMPLE_W);

    logic                primed_q;
    logic                started_q;
    logic                lr_prev_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [SAMPLE_W-1:0] sr_q;

    logic                chg;
    logic [CNT_W-1:0]    cnt_nx;
    logic [SAMPLE_W-1:0] sr_nx;
    word_t               word_nx;

    always_comb begin
        chg   = primed_q && (lr != lr_prev_q);
        sr_nx = {sr_q[SAMPLE_W-2:0], din};
        if (chg)                  cnt_nx = (cfg.frame == FR_LJ) ? CNT_W'(1) : '0;
        else if (cnt_q == CNT_MAX) cnt_nx = CNT_MAX;
        else                      cnt_nx = cnt_q + CNT_W'(1);

        word_nx = '0;
        if (rise) begin
            if (cfg.frame == FR_RJ) begin
                // word ends at the transition: previous bits are the sample
                word_nx.valid   = chg && started_q;
                word_nx.is_left = lr_prev_q;
                word_nx.data    = sign_extend(sr_q, cfg.len);
            end else begin
                word_nx.valid   = (cnt_nx == CNT_DONE);
                word_nx.is_left = (cfg.frame == FR_LJ) ? lr : ~lr;
                word_nx.data    = sr_nx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            primed_q  <= 1'b0;
            started_q <= 1'b0;
            lr_prev_q <= 1'b0;
            cnt_q     <= CNT_MAX;
            sr_q      <= '0;
            word_o    <= '0;
        end else begin
            word_o <= word_nx;
            if (rise) begin
                primed_q  <= 1'b1;
                lr_prev_q <= lr;
                sr_q      <= sr_nx;
                cnt_q     <= cnt_nx;
                if (chg) started_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair
    import aud_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  word_t               word_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    logic [SAMPLE_W-1:0] left_hold_q;
    logic                have_left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold_q <= '0;
            have_left_q <= 1'b0;
            left_o      <= '0;
            right_o     <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (word_i.valid) begin
                if (word_i.is_left) begin
                    left_hold_q <= word_i.data;
                    have_left_q <= 1'b1;
                end else if (have_left_q) begin
                    left_o      <= left_hold_q;
                    right_o     <= word_i.data;
                    valid_o     <= 1'b1;
                    have_left_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/aud_rx_top.sv
module aud_rx_top
    import aud_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_SLOT    = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fmt_wr_i,
    input  logic [FMT_W-1:0]    fmt_i,
    input  logic                bck_i,
    input  logic                lrck_i,
    input  logic                sdata_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    logic [FMT_W-1:0] fmt_q;
    logic [2:0]       pins_s;
    logic             bck_s, lr_s, dat_s;
    logic             bck_q;
    logic             bck_rise;
    fmt_cfg_t         cfg;
    word_t            word;

    always_ff @(posedge clk) begin
        if (rst)           fmt_q <= FMT_I2S24;
        else if (fmt_wr_i) fmt_q <= fmt_i;
    end

    assign cfg = decode_fmt(fmt_q);

    aud_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  ({bck_i, lrck_i, sdata_i}),
        .dout (pins_s)
    );

    assign {bck_s, lr_s, dat_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) bck_q <= 1'b0;
        else     bck_q <= bck_s;
    end

    assign bck_rise = bck_s & ~bck_q;

    aud_rx_shift #(.MAX_SLOT(MAX_SLOT)) shift_i (
        .clk    (clk),
        .rst    (rst),
        .rise   (bck_rise),
        .lr     (lr_s),
        .din    (dat_s),
        .cfg    (cfg),
        .word_o (word)
    );

    aud_rx_pair pair_i (
        .clk     (clk),
        .rst     (rst),
        .word_i  (word),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );
endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk
    import aud_rx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                valid_o,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic [FMT_W-1:0]    fmt_q,
    input logic                bck_rise
);
    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R9
    left_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(left_o) |-> valid_o);

    // R9
    right_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(right_o) |-> valid_o);

    // R2
    reset_fmt_chk: assert property (@(posedge clk)
        rst |=> (fmt_q == FMT_I2S24));

    // R1
    rise_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(bck_rise, 2));

    // R5
    rj16_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && fmt_q == FMT_RJ16) |->
            (left_o[SAMPLE_W-1:16] == {(SAMPLE_W-16){left_o[15]}} &&
             right_o[SAMPLE_W-1:16] == {(SAMPLE_W-16){right_o[15]}}));
endmodule

bind aud_rx_top aud_rx_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .valid_o  (valid_o),
    .left_o   (left_o),
    .right_o  (right_o),
    .fmt_q    (fmt_q),
    .bck_rise (bck_rise)
);

// File: tb/aud_rx_top_tb_top.sv
module aud_rx_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fmt_wr = 1'b0;
    logic [2:0]  fmt = 3'b000;
    logic        bck = 1'b0;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int errors = 0;
    int checks = 0;
    int cap_n  = 0;
    int long_n = 0;
    logic        prev_valid = 1'b0;
    logic [23:0] cap_l = '0, cap_r = '0;

    always #5 clk = ~clk;

    aud_rx_top dut_i (
        .clk(clk), .rst(rst), .fmt_wr_i(fmt_wr), .fmt_i(fmt),
        .bck_i(bck), .lrck_i(lrck), .sdata_i(sdata),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (valid_o) begin
                cap_n = cap_n + 1;
                cap_l = left_o;
                cap_r = right_o;
                if (prev_valid) long_n = long_n + 1;
            end
            prev_valid = valid_o;
        end else begin
            prev_valid = 1'b0;
        end
    end

    // {fmt, left, right, left slot length, right slot length}
    localparam logic [62:0] VEC [12] = '{
        {3'd0, 24'h123456, 24'hABCDEF, 6'd32, 6'd32},
        {3'd1, 24'h800001, 24'h7FFFFE, 6'd32, 6'd32},
        {3'd2, 24'hA5A5A5, 24'h5A5A5A, 6'd32, 6'd32},
        {3'd3, 24'h0F8001, 24'h070001, 6'd32, 6'd32},
        {3'd4, 24'h020000, 24'h01FFFF, 6'd32, 6'd32},
        {3'd5, 24'h008000, 24'h007FFF, 6'd32, 6'd32},
        {3'd0, 24'h000001, 24'hFFFFFF, 6'd30, 6'd34},
        {3'd1, 24'hC00003, 24'h3FFFFC, 6'd34, 6'd30},
        {3'd5, 24'h00F00F, 24'h000FF0, 6'd30, 6'd34},
        {3'd2, 24'h800000, 24'h000001, 6'd34, 6'd30},
        {3'd7, 24'h654321, 24'hFEDCBA, 6'd32, 6'd32},
        {3'd6, 24'h0C0FFE, 24'hBADF00, 6'd32, 6'd30}
    };

    function automatic int fmt_len(input logic [2:0] f);
        case (f)
            3'd3: return 20;
            3'd4: return 18;
            3'd5: return 16;
            default: return 24;
        endcase
    endfunction

    function automatic bit is_rj(input logic [2:0] f);
        return (f >= 3'd2 && f <= 3'd5);
    endfunction

    function automatic bit is_lj(input logic [2:0] f);
        return f == 3'd1;
    endfunction

    function automatic logic [23:0] expect_val(input logic [2:0] f, input logic [23:0] v);
        logic [23:0] r;
        int n;
        n = is_rj(f) ? fmt_len(f) : 24;
        for (int i = 0; i < 24; i++) r[i] = (i < n) ? v[i] : v[n-1];
        return r;
    endfunction

    function automatic logic bit_at(input logic [2:0] f, input logic [23:0] v,
                                    input int k, input int w);
        int n;
        if (is_rj(f)) begin
            n = fmt_len(f);
            if (k >= w - n) return v[n - 1 - (k - (w - n))];
            return 1'b0;
        end
        if (is_lj(f)) return (k < 24) ? v[23 - k] : 1'b0;
        return (k >= 1 && k <= 24) ? v[24 - k] : 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bck_bit(input logic lr, input logic d);
        lrck  = lr;
        sdata = d;
        repeat (4) @(negedge clk);
        bck = 1'b1;
        repeat (4) @(negedge clk);
        bck = 1'b0;
    endtask

    task automatic send_slot(input logic [2:0] f, input logic lr, input logic [23:0] v,
                             input int w);
        for (int k = 0; k < w; k++) bck_bit(lr, bit_at(f, v, k, w));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fmt_wr = 1'b0;
        bck = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_fmt(input logic [2:0] f);
        fmt = f;
        fmt_wr = 1'b1;
        @(negedge clk);
        fmt_wr = 1'b0;
    endtask

    task automatic run_frame(input logic [2:0] f, input logic [23:0] l, input logic [23:0] r,
                             input int wl, input int wr);
        logic left_lvl;
        left_lvl = (is_lj(f) || is_rj(f)) ? 1'b1 : 1'b0;
        cap_n  = 0;
        long_n = 0;
        send_slot(f, ~left_lvl, 24'h0, 32);
        send_slot(f, left_lvl, l, wl);
        send_slot(f, ~left_lvl, r, wr);
        send_slot(f, left_lvl, 24'h0, 32);
        repeat (10) @(negedge clk);
    endtask

    task automatic check_frame(input string req, input logic [2:0] f,
                               input logic [23:0] l, input logic [23:0] r);
        check(cap_n == 1, {req, " pair count"}, 32'(cap_n), 32'd1);
        check(cap_l == expect_val(f, l), {req, " left"}, {8'h0, cap_l}, {8'h0, expect_val(f, l)});
        check(cap_r == expect_val(f, r), {req, " right"}, {8'h0, cap_r}, {8'h0, expect_val(f, r)});
        check(long_n == 0, "R9 pulse width", 32'(long_n), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        string tag;
        do_reset();
        // R2: reset state
        check(left_o == 24'h0 && right_o == 24'h0, "R2 outputs zero", {8'h0, left_o}, 32'h0);
        check(valid_o == 1'b0, "R2 valid low", {31'h0, valid_o}, 32'h0);

        for (int i = 0; i < 12; i++) begin
            logic [2:0]  f;
            logic [23:0] l, r;
            int wl, wr;
            {f, l, r} = VEC[i][62:12];
            wl = int'(VEC[i][11:6]);
            wr = int'(VEC[i][5:0]);
            do_reset();
            write_fmt(f);
            run_frame(f, l, r, wl, wr);
            if (f == 3'd0)      tag = (wl != wr) ? "R8 R3 i2s skew" : "R3 i2s";
            else if (f == 3'd1) tag = (wl != wr) ? "R8 R4 lj skew" : "R4 lj";
            else if (is_rj(f))  tag = (wl != wr) ? "R8 R5 rj skew" : "R5 rj";
            else                tag = "R6 fallback";
            check_frame(tag, f, l, r);
            // R9: outputs hold after the pulse
            check(left_o == expect_val(f, l), "R9 left held", {8'h0, left_o},
                  {8'h0, expect_val(f, l)});
        end

        // R2: outputs cleared by reset after a capture
        do_reset();
        check(left_o == 24'h0 && right_o == 24'h0, "R2 cleared", {8'h0, right_o}, 32'h0);

        // R7 R2: format register back at I2S; fmt_i without the strobe ignored
        write_fmt(3'd1);
        do_reset();
        fmt = 3'd1;
        run_frame(3'd0, 24'h13579B, 24'h2468AC, 32, 32);
        check_frame("R7 default i2s", 3'd0, 24'h13579B, 24'h2468AC);

        // R10: right word first, no left before it
        do_reset();
        write_fmt(3'd0);
        cap_n = 0;
        send_slot(3'd0, 1'b0, 24'h111111, 32);
        send_slot(3'd0, 1'b1, 24'h222222, 32);
        send_slot(3'd0, 1'b0, 24'h333333, 32);
        repeat (10) @(negedge clk);
        check(cap_n == 0, "R10 no pair", 32'(cap_n), 32'd0);

        // R1: two frames back to back, second pair replaces the first
        do_reset();
        write_fmt(3'd1);
        cap_n = 0;
        send_slot(3'd1, 1'b0, 24'h0, 32);
        send_slot(3'd1, 1'b1, 24'hF0F0F0, 32);
        send_slot(3'd1, 1'b0, 24'h0F0F0F, 32);
        send_slot(3'd1, 1'b1, 24'h8C8C8C, 32);
        send_slot(3'd1, 1'b0, 24'h313131, 32);
        send_slot(3'd1, 1'b1, 24'h0, 32);
        repeat (10) @(negedge clk);
        check(cap_n == 2, "R1 stream pairs", 32'(cap_n), 32'd2);
        check(cap_l == 24'h8C8C8C && cap_r == 24'h313131, "R1 stream data",
              {8'h0, cap_l}, 32'h008C8C8C);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule